// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block turns a pixel clock into three free-running, active-high strobes: a frame strobe (vertical sync), a line strobe (horizontal sync) and an active-video strobe (data enable). Every interval is a plain count of pixel clocks held in a small byte-wide register file. The frame strobe is set by a one-time lead-in delay, a high time and a low time; together the high and low times define the frame period. The line strobe and the active-video strobe each have an offset from the start of the frame, a high count, a low count and a number of repetitions per frame.

Alongside the strobes the block reports the column and the row of the current active pixel, so that a pattern source further down the pipeline can pick the colour of each pixel without counters of its own. A single enable bit starts and stops the generator. The timing used inside a frame is a snapshot that is taken at the frame boundary, so a frame never mixes old and new settings.

Top module: `video_timing_gen`

## Requirements
- R1: After reset the enable bit is clear, and `vsync`, `hsync` and `de` stay low until the enable bit is written to 1.
- R2: Register byte map (multi-byte fields are stored most significant byte at the lowest address): 0x00 bit 0 = enable, with the other bits ignored; 0x01-0x02 line high; 0x03-0x04 line low; 0x05-0x06 line count; 0x07-0x09 line offset; 0x0A-0x0B active high; 0x0C-0x0D active low; 0x0E-0x0F active line count; 0x10-0x12 active offset; 0x13-0x15 frame high; 0x16-0x18 frame low; 0x19-0x1B lead-in delay. A write to any other address changes nothing.
- R3: On the clock after the enable bit reads 1 (when it was previously 0), the outputs stay low for lead-in delay clocks. Frames then follow back to back, each frame high + frame low clocks long, with `vsync` high for the first frame-high clocks of each frame.
- R4: Within a frame, `hsync` is low for line-offset clocks and then repeats line-count periods of line-high clocks high and line-low clocks low. It stays low for the rest of the frame.
- R5: `de` follows the same rule as `hsync` using the active offset, active high, active low and active line count.
- R6: While `de` is high, `pix_x` equals the number of clocks since `de` rose in the current line (starting at 0), and `line_y` equals the index of the current active line in the frame (starting at 0).
- R7: From the first clock on which the enable bit reads 0, all three strobes are low. Enabling again restarts with the lead-in delay.
- R8: Register writes take effect only at the start of the next frame, or when the block leaves the disabled state. A frame in progress keeps its timing.
- R9: The reset values give 1920x1080 timing with a 2200-clock line: line 44 high, 2156 low, 1125 lines, offset 0; active 1920 high, 280 low, 1080 lines, offset 90392; frame 11000 high, 2464000 low; lead-in 0.
- R10: A new frame restarts the line and active sequences even if they have not finished. A count of zero lines, or a high count of zero, keeps that strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register byte write strobe |
| cfg_addr | input | ADDR_W (6) | Register byte address |
| cfg_wdata | input | 8 | Register byte write data |
| vsync | output | 1 | Frame strobe, active high |
| hsync | output | 1 | Line strobe, active high |
| de | output | 1 | Active-video strobe, active high |
| pix_x | output | 16 | Column of the current active pixel, valid while `de` is high |
| line_y | output | 16 | Row of the current active line, valid while `de` is high |

## Verification
The assertions assume the programmed frame period and line periods are non-zero, and that each period fits its field when the high and low counts are added. They also assume an active line is never longer than one frame, so the column count can only advance or return to zero. The stimulus only uses small non-zero periods, or the reset timing. Zero appears only as a line count, a high count or an offset, which R10 covers. Writes are issued during running frames as well as while the block is disabled, so that the boundary snapshot is exercised.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    localparam int LW = 24;
    localparam int SW = 16;

    typedef struct packed {
        logic [SW-1:0] hi;
        logic [SW-1:0] lo;
        logic [SW-1:0] lines;
        logic [LW-1:0] dly;
    } strobe_cfg_t;

    typedef struct packed {
        logic [LW-1:0] hi;
        logic [LW-1:0] lo;
        logic [LW-1:0] dly;
    } vert_cfg_t;

    typedef struct packed {
        vert_cfg_t   v;
        strobe_cfg_t h;
        strobe_cfg_t d;
    } timing_cfg_t;

    typedef enum logic [1:0] {MODE_OFF, MODE_LEAD, MODE_FRAME} mode_e;
    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN, ST_DONE} unit_e;

    localparam int RST_LINE   = 2200;
    localparam int RST_LINES  = 1125;
    localparam timing_cfg_t RST_CFG = '{
        v: '{hi: LW'(5 * RST_LINE), lo: LW'(1120 * RST_LINE), dly: '0},
        h: '{hi: SW'(44), lo: SW'(RST_LINE - 44), lines: SW'(RST_LINES), dly: '0},
        d: '{hi: SW'(1920), lo: SW'(280), lines: SW'(1080),
             dly: LW'(41 * RST_LINE + 192)}
    };
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              en,
    output timing_cfg_t       cfg
);
    typedef struct packed {
        logic        en;
        timing_cfg_t cfg;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (addr)
                ADDR_W'(0):  r_d.en              = wdata[0];
                ADDR_W'(1):  r_d.cfg.h.hi[15:8]    = wdata;
                ADDR_W'(2):  r_d.cfg.h.hi[7:0]     = wdata;
                ADDR_W'(3):  r_d.cfg.h.lo[15:8]    = wdata;
                ADDR_W'(4):  r_d.cfg.h.lo[7:0]     = wdata;
                ADDR_W'(5):  r_d.cfg.h.lines[15:8] = wdata;
                ADDR_W'(6):  r_d.cfg.h.lines[7:0]  = wdata;
                ADDR_W'(7):  r_d.cfg.h.dly[23:16]  = wdata;
                ADDR_W'(8):  r_d.cfg.h.dly[15:8]   = wdata;
                ADDR_W'(9):  r_d.cfg.h.dly[7:0]    = wdata;
                ADDR_W'(10): r_d.cfg.d.hi[15:8]    = wdata;
                ADDR_W'(11): r_d.cfg.d.hi[7:0]     = wdata;
                ADDR_W'(12): r_d.cfg.d.lo[15:8]    = wdata;
                ADDR_W'(13): r_d.cfg.d.lo[7:0]     = wdata;
                ADDR_W'(14): r_d.cfg.d.lines[15:8] = wdata;
                ADDR_W'(15): r_d.cfg.d.lines[7:0]  = wdata;
                ADDR_W'(16): r_d.cfg.d.dly[23:16]  = wdata;
                ADDR_W'(17): r_d.cfg.d.dly[15:8]   = wdata;
                ADDR_W'(18): r_d.cfg.d.dly[7:0]    = wdata;
                ADDR_W'(19): r_d.cfg.v.hi[23:16]   = wdata;
                ADDR_W'(20): r_d.cfg.v.hi[15:8]    = wdata;
                ADDR_W'(21): r_d.cfg.v.hi[7:0]     = wdata;
                ADDR_W'(22): r_d.cfg.v.lo[23:16]   = wdata;
                ADDR_W'(23): r_d.cfg.v.lo[15:8]    = wdata;
                ADDR_W'(24): r_d.cfg.v.lo[7:0]     = wdata;
                ADDR_W'(25): r_d.cfg.v.dly[23:16]  = wdata;
                ADDR_W'(26): r_d.cfg.v.dly[15:8]   = wdata;
                ADDR_W'(27): r_d.cfg.v.dly[7:0]    = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{en: 1'b0, cfg: RST_CFG};
        end else begin
            r_q <= r_d;
        end
    end

    assign en  = r_q.en;
    assign cfg = r_q.cfg;
endmodule

// File: rtl/vtg_strobe.sv
module vtg_strobe
    import vtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_d,
    input  logic          start_d,
    input  strobe_cfg_t   cfg_nxt,
    input  logic [SW-1:0] hi_cur,
    output logic          strobe,
    output logic [SW-1:0] col,
    output logic [SW-1:0] row
);
    typedef struct packed {
        unit_e         st;
        logic [LW-1:0] cnt;
        logic [SW:0]   ph;
        logic [SW-1:0] ln;
    } ustate_t;

    ustate_t s_d, s_q;
    logic [SW:0] per_m1;
    unit_e       run_st;

    always_comb begin
        per_m1 = ({1'b0, cfg_nxt.hi} + {1'b0, cfg_nxt.lo}) - (SW+1)'(1);
        run_st = (cfg_nxt.lines == '0) ? ST_DONE : ST_RUN;
        s_d    = s_q;
        if (!run_d) begin
            s_d.st = ST_IDLE;
        end else if (start_d) begin
            s_d.cnt = '0;
            s_d.ph  = '0;
            s_d.ln  = '0;
            s_d.st  = (cfg_nxt.dly == '0) ? run_st : ST_WAIT;
        end else begin
            case (s_q.st)
                ST_WAIT: begin
                    if (s_q.cnt == cfg_nxt.dly - LW'(1)) begin
                        s_d.st = run_st;
                        s_d.ph = '0;
                        s_d.ln = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + LW'(1);
                    end
                end
                ST_RUN: begin
                    if (s_q.ph == per_m1) begin
                        s_d.ph = '0;
                        if (s_q.ln == cfg_nxt.lines - SW'(1)) begin
                            s_d.st = ST_DONE;
                        end else begin
                            s_d.ln = s_q.ln + SW'(1);
                        end
                    end else begin
                        s_d.ph = s_q.ph + (SW+1)'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign strobe = (s_q.st == ST_RUN) && (s_q.ph < {1'b0, hi_cur});
    assign col    = s_q.ph[SW-1:0];
    assign row    = s_q.ln;
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
    import vtg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic              vsync,
    output logic              hsync,
    output logic              de,
    output logic [SW-1:0]     pix_x,
    output logic [SW-1:0]     line_y
);
    localparam int NUM_UNITS = 2;
    localparam int U_LINE    = 0;
    localparam int U_ACT     = 1;

    typedef struct packed {
        mode_e       mode;
        logic [LW:0] t;
        timing_cfg_t shadow;
    } frame_t;

    logic        gen_en;
    timing_cfg_t reg_cfg;
    frame_t      f_d, f_q;
    logic        start_d;
    logic        run_d;
    logic [LW:0] period_m1;
    logic [LW:0] lead_m1;

    vtg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .en    (gen_en),
        .cfg   (reg_cfg)
    );

    always_comb begin
        period_m1 = ({1'b0, f_q.shadow.v.hi} + {1'b0, f_q.shadow.v.lo}) - (LW+1)'(1);
        lead_m1   = {1'b0, f_q.shadow.v.dly} - (LW+1)'(1);
        f_d       = f_q;
        start_d   = 1'b0;
        if (!gen_en) begin
            f_d.mode = MODE_OFF;
            f_d.t    = '0;
        end else begin
            case (f_q.mode)
                MODE_OFF: begin
                    f_d.shadow = reg_cfg;
                    f_d.t      = '0;
                    if (reg_cfg.v.dly == '0) begin
                        f_d.mode = MODE_FRAME;
                        start_d  = 1'b1;
                    end else begin
                        f_d.mode = MODE_LEAD;
                    end
                end
                MODE_LEAD: begin
                    if (f_q.t == lead_m1) begin
                        f_d.mode   = MODE_FRAME;
                        f_d.t      = '0;
                        f_d.shadow = reg_cfg;
                        start_d    = 1'b1;
                    end else begin
                        f_d.t = f_q.t + (LW+1)'(1);
                    end
                end
                MODE_FRAME: begin
                    if (f_q.t == period_m1) begin
                        f_d.t      = '0;
                        f_d.shadow = reg_cfg;
                        start_d    = 1'b1;
                    end else begin
                        f_d.t = f_q.t + (LW+1)'(1);
                    end
                end
                default: f_d.mode = MODE_OFF;
            endcase
        end
        run_d = (f_d.mode == MODE_FRAME);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{mode: MODE_OFF, t: '0, shadow: RST_CFG};
        end else begin
            f_q <= f_d;
        end
    end

    strobe_cfg_t   u_nxt [NUM_UNITS];
    logic [SW-1:0] u_hi  [NUM_UNITS];
    logic          u_str [NUM_UNITS];
    logic [SW-1:0] u_col [NUM_UNITS];
    logic [SW-1:0] u_row [NUM_UNITS];

    assign u_nxt[U_LINE] = f_d.shadow.h;
    assign u_nxt[U_ACT]  = f_d.shadow.d;
    assign u_hi[U_LINE]  = f_q.shadow.h.hi;
    assign u_hi[U_ACT]   = f_q.shadow.d.hi;

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        vtg_strobe u_strobe (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_d   (run_d),
            .start_d (start_d),
            .cfg_nxt (u_nxt[g]),
            .hi_cur  (u_hi[g]),
            .strobe  (u_str[g]),
            .col     (u_col[g]),
            .row     (u_row[g])
        );
    end

    assign vsync  = gen_en && (f_q.mode == MODE_FRAME) && (f_q.t < {1'b0, f_q.shadow.v.hi});
    assign hsync  = gen_en && u_str[U_LINE];
    assign de     = gen_en && u_str[U_ACT];
    assign pix_x  = u_col[U_ACT];
    assign line_y = u_row[U_ACT];
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk
    import vtg_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          vsync,
    input logic          hsync,
    input logic          de,
    input logic [SW-1:0] pix_x,
    input logic [SW-1:0] line_y,
    input logic [SW-1:0] hs_col,
    input logic [SW-1:0] hs_row,
    input mode_e         mode,
    input logic [LW:0]   t,
    input timing_cfg_t   shadow
);
    // R7
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!vsync && !hsync && !de));

    // R3
    vs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) |-> (t == '0));

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FRAME && t != '0) |-> $stable(shadow));

    // R6
    col_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(de) |-> (pix_x == '0));

    // R6
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (de && pix_x != '0) |-> ($past(de) && pix_x == $past(pix_x) + SW'(1)));

    // R6
    row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (line_y < shadow.d.lines));

    // R4
    hs_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> (hs_row < shadow.h.lines));

    // R4
    hs_col_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync) |-> (hs_col == '0));
endmodule

bind video_timing_gen vtg_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (gen_en),
    .vsync  (vsync),
    .hsync  (hsync),
    .de     (de),
    .pix_x  (pix_x),
    .line_y (line_y),
    .hs_col (u_col[0]),
    .hs_row (u_row[0]),
    .mode   (f_q.mode),
    .t      (f_q.t),
    .shadow (f_q.shadow)
);

// File: tb/video_timing_gen_tb_top.sv
module video_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        vsync, hsync, de;
    logic [15:0] pix_x, line_y;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    typedef struct {
        int en, vhi, vlo, vdly;
        int hhi, hlo, hln, hdly;
        int dhi, dlo, dln, ddly;
    } bcfg_t;

    bcfg_t m_regs, act;
    int mst = 0;   // 0 off, 1 lead-in, 2 frame
    int mc = 0;
    int mt = 0;

    always #2 clk = ~clk;

    video_timing_gen #(.ADDR_W(6)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .vsync     (vsync),
        .hsync     (hsync),
        .de        (de),
        .pix_x     (pix_x),
        .line_y    (line_y)
    );

    function automatic int put(int old, int nb, int k, int d);
        int sh = 8 * (nb - 1 - k);
        return (old & ~(255 << sh)) | ((d & 255) << sh);
    endfunction

    // R2 byte map, most significant byte first
    function automatic void apply(int a, int d);
        case (a) inside
            0:       m_regs.en   = d & 1;
            [1:2]:   m_regs.hhi  = put(m_regs.hhi, 2, a - 1, d);
            [3:4]:   m_regs.hlo  = put(m_regs.hlo, 2, a - 3, d);
            [5:6]:   m_regs.hln  = put(m_regs.hln, 2, a - 5, d);
            [7:9]:   m_regs.hdly = put(m_regs.hdly, 3, a - 7, d);
            [10:11]: m_regs.dhi  = put(m_regs.dhi, 2, a - 10, d);
            [12:13]: m_regs.dlo  = put(m_regs.dlo, 2, a - 12, d);
            [14:15]: m_regs.dln  = put(m_regs.dln, 2, a - 14, d);
            [16:18]: m_regs.ddly = put(m_regs.ddly, 3, a - 16, d);
            [19:21]: m_regs.vhi  = put(m_regs.vhi, 3, a - 19, d);
            [22:24]: m_regs.vlo  = put(m_regs.vlo, 3, a - 22, d);
            [25:27]: m_regs.vdly = put(m_regs.vdly, 3, a - 25, d);
            default: ;
        endcase
    endfunction

    function automatic void seval(input int t, input int dly, input int hi, input int lo,
                                  input int ln, output bit o, output int col, output int row);
        o = 1'b0; col = 0; row = 0;
        if (t >= dly && hi + lo > 0) begin
            row = (t - dly) / (hi + lo);
            col = (t - dly) % (hi + lo);
            o   = (row < ln) && (col < hi);
        end
    endfunction

    task automatic chk(input string req, input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s (phase %s): got %0d expected %0d", req, what, tag, got, exp);
        end
    endtask

    task automatic check_now();
        bit on, vs_e, hs_e, de_e;
        int hc, hr, dc, dr;
        on   = (m_regs.en != 0) && (mst == 2);
        vs_e = on && (mt < act.vhi);
        seval(mt, act.hdly, act.hhi, act.hlo, act.hln, hs_e, hc, hr);
        seval(mt, act.ddly, act.dhi, act.dlo, act.dln, de_e, dc, dr);
        hs_e = hs_e && on;
        de_e = de_e && on;
        chk("R3", int'(vsync), int'(vs_e), "vsync");
        chk("R4", int'(hsync), int'(hs_e), "hsync");
        chk("R5", int'(de), int'(de_e), "de");
        if (de_e && de) begin
            chk("R6", int'(pix_x), dc, "pix_x");
            chk("R6", int'(line_y), dr, "line_y");
        end
    endtask

    task automatic advance();
        if (m_regs.en == 0) begin
            mst = 0;
        end else if (mst == 0) begin
            act = m_regs;
            if (act.vdly == 0) begin mst = 2; mt = 0; end
            else begin mst = 1; mc = 0; end
        end else if (mst == 1) begin
            if (mc == act.vdly - 1) begin mst = 2; mt = 0; act = m_regs; end
            else mc++;
        end else begin
            if (mt == act.vhi + act.vlo - 1) begin mt = 0; act = m_regs; end
            else mt++;
        end
    endtask

    task automatic cyc(input bit we, input int a, input int d);
        @(negedge clk);
        check_now();
        cfg_we    = we;
        cfg_addr  = a[5:0];
        cfg_wdata = d[7:0];
        advance();
        if (we) apply(a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 0);
    endtask

    task automatic wfield(input int base, input int nb, input int val);
        for (int k = 0; k < nb; k++) cyc(1'b1, base + k, (val >> (8 * (nb - 1 - k))) & 255);
    endtask

    task automatic wall(input bcfg_t c);
        wfield(1, 2, c.hhi);  wfield(3, 2, c.hlo);
        wfield(5, 2, c.hln);  wfield(7, 3, c.hdly);
        wfield(10, 2, c.dhi); wfield(12, 2, c.dlo);
        wfield(14, 2, c.dln); wfield(16, 3, c.ddly);
        wfield(19, 3, c.vhi); wfield(22, 3, c.vlo);
        wfield(25, 3, c.vdly);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        bcfg_t ca, cb;
        // R9 reset values, taken from the requirement
        m_regs = '{en: 0, vhi: 11000, vlo: 2464000, vdly: 0,
                   hhi: 44, hlo: 2156, hln: 1125, hdly: 0,
                   dhi: 1920, dlo: 280, dln: 1080, ddly: 90392};
        act = m_regs;

        // R1: outputs low while reset is applied and after release
        repeat (3) @(negedge clk);
        chk("R1", int'(vsync | hsync | de), 0, "strobes in reset");
        rst_n = 1'b1;
        idle(20);

        // R9: reset timing; the first lines of the frame
        tag = "R9";
        cyc(1'b1, 0, 1);
        idle(12000);
        cyc(1'b1, 0, 0);
        idle(4);

        // R3 R4 R5 R6: small timing with a lead-in
        tag = "R3";
        ca = '{en: 0, vhi: 14, vlo: 14, vdly: 3, hhi: 2, hlo: 5, hln: 4, hdly: 0,
               dhi: 3, dlo: 4, dln: 2, ddly: 10};
        wall(ca);
        cyc(1'b1, 0, 1);
        idle(100);

        // R4 R5: offsets on both strobes, no lead-in; written during running frames (R8)
        tag = "R8";
        cb = '{en: 0, vhi: 1, vlo: 29, vdly: 0, hhi: 3, hlo: 3, hln: 3, hdly: 5,
               dhi: 4, dlo: 2, dln: 3, ddly: 7};
        wall(cb);
        idle(90);

        // R5 sweep of high and low counts while running
        tag = "R5";
        for (int hh = 0; hh < 3; hh++) begin
            for (int ll = 1; ll < 3; ll++) begin
                wfield(1, 2, hh + 1);
                wfield(3, 2, ll);
                wfield(10, 2, hh);
                wfield(12, 2, ll);
                wfield(16, 3, hh + ll);
                idle(70);
            end
        end

        // R10: truncation at the frame boundary and a zero line count
        tag = "R10";
        wfield(5, 2, 0);
        wfield(14, 2, 10);
        wfield(10, 2, 3);
        idle(100);

        // R2: unmapped addresses and unused control bits change nothing
        tag = "R2";
        for (int a = 28; a < 64; a++) cyc(1'b1, a, 8'h5A);
        cyc(1'b1, 0, 8'hFF);
        idle(70);

        // R7: disable mid-frame, then re-enable with a new lead-in
        tag = "R7";
        wfield(25, 3, 4);
        idle(7);
        cyc(1'b1, 0, 0);
        idle(12);
        cyc(1'b1, 0, 1);
        idle(80);

        summary();
        $finish;
    end
endmodule